// File: doc/BRIEF.md
# ADC Code Histogram Linearity Analyzer

The block measures the static linearity of an N-bit analog-to-digital converter. A slow linear ramp drives the converter input, and each output code arrives here as a valid/code sample. During an acquisition window that opens on a start pulse and closes on a stop pulse, every sample adds one to the occurrence count of its code in an on-chip count store. Because the ramp is slow compared with the conversion time, each count grows in proportion to the analog width of that code's step.

The stop pulse launches an analysis pass. First the counts of the interior codes are summed. The two end codes also collect input from beyond the range, so they take no part in the average. Then the codes are visited in ascending order. For each interior code a sequential divider forms the ratio of its count to the ideal average count, and the block reports differential nonlinearity as that ratio minus one LSB. End-point integral nonlinearity is reported as a running sum of the DNL values. Every code produces one result beat carrying the code, its count, a missing-code bit, DNL and INL, both in signed fixed point with `FRAC_W` fraction bits. Sticky flags report a saturated counter, a missing code and a DNL magnitude above one LSB.

Top module: `adc_hist_linearity`

## Requirements
- R1: A sample is counted only while the acquisition window is open, that is from the cycle after `acq_start` up to and including the cycle in which `acq_stop` is seen. Samples that arrive before the window or during the analysis pass leave the reported counts unchanged.
- R2: A count that has reached 2^CNT_W-1 stays there. A further sample for that code sets `ovf_flag` from the next clock edge, and the flag stays set until a clear.
- R3: `cnt_clear` outside the analysis pass zeroes every count and `ovf_flag` and closes the window. During the pass it has no effect on the counts being reported.
- R4: After `acq_stop` the block raises `busy` and emits exactly one `res_valid` beat per code, for codes 0 through 2^N-1 in ascending order. Each beat lasts one cycle, `res_last` is set only on the beat for the all-ones code, and `busy` is low again after that beat.
- R5: Let T be the sum of the counts of codes 1 through 2^N-2. For such an interior code k, `res_dnl` = floor(count(k)·(2^N-2)·2^FRAC_W / T) − 2^FRAC_W, in two's complement. The 2^FRAC_W term stands for one LSB.
- R6: The beats for code 0 and for the all-ones code carry `res_dnl` = 0.
- R7: `res_inl` for code k is the sum of `res_dnl` over codes 1 through k−1. Codes 0 and 1 therefore report 0, and the all-ones code reports the sum over all interior codes.
- R8: `res_missing` is 1 exactly when the beat's count is zero. `missing_any` is set after a pass in which any code, end codes included, had a zero count.
- R9: `dnl_exceed` is set after a pass in which some interior code had |DNL| strictly greater than 2^FRAC_W. A DNL of exactly +2^FRAC_W does not set it.
- R10: If T is zero, every interior code reports DNL = −2^FRAC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A converter output code is present this cycle |
| smp_code | input | CODE_W | Converter output code |
| acq_start | input | 1 | Opens the acquisition window from idle or after a pass |
| acq_stop | input | 1 | Closes the window and starts the analysis pass |
| cnt_clear | input | 1 | Zeroes counts and flags and returns to idle (ignored while busy) |
| busy | output | 1 | Analysis pass in progress |
| acq_active | output | 1 | Acquisition window open |
| res_valid | output | 1 | Result beat present |
| res_last | output | 1 | Beat belongs to the all-ones code |
| res_code | output | CODE_W | Code of this beat |
| res_count | output | CNT_W | Occurrence count of the code |
| res_missing | output | 1 | Count is zero |
| res_dnl | output | CODE_W+CNT_W+FRAC_W+1 | Signed DNL, FRAC_W fraction bits |
| res_inl | output | 2·CODE_W+CNT_W+FRAC_W+1 | Signed end-point INL, FRAC_W fraction bits |
| ovf_flag | output | 1 | Some count saturated |
| missing_any | output | 1 | Last pass found a code with zero count |
| dnl_exceed | output | 1 | Last pass found an interior |DNL| above one LSB |

## Verification
The bench goes after the places where a histogram analyzer usually slips. It checks that the end codes are kept out of the average; if they were not, the uniform ramp with heavy end bins would report a large negative DNL instead of zero. It drives samples into the idle window and into the analysis pass and pulses a clear in the middle of the pass; an analyzer that honours either would report changed counts on the beats that follow. It checks an exact two-LSB step, which must report +1 LSB without raising the exceed flag, and an INL that is off by one code would show up there as a shifted sum. It also runs an empty histogram to check the divide-by-zero rule, and it pushes one code past its counter ceiling; a counter that wraps would report a small count and leave the overflow flag low.

// File: rtl/adc_hist_pkg.sv
package adc_hist_pkg;

  // Sequencer states of the analyzer.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_SUM,
    ST_LOAD,
    ST_DIV,
    ST_EMIT,
    ST_DONE
  } hist_st_e;

endpackage

// File: rtl/hist_count_mem.sv
// One saturating occurrence counter per converter code.
module hist_count_mem #(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc_en,
  input  logic [CODE_W-1:0] inc_code,
  input  logic [CODE_W-1:0] rd_code,
  output logic [CNT_W-1:0]  rd_cnt,
  output logic              sat_hit
);

  localparam int NCODE = 1 << CODE_W;

  logic [CNT_W-1:0] cnt_q [NCODE];
  logic [CNT_W-1:0] cnt_d [NCODE];
  logic [CNT_W-1:0] sel_cnt;
  logic             at_max;

  assign sel_cnt = cnt_q[inc_code];
  assign at_max  = &sel_cnt;
  assign sat_hit = inc_en && at_max && !clr;
  assign rd_cnt  = cnt_q[rd_code];

  for (genvar g = 0; g < NCODE; g++) begin : g_bin
    logic hit;
    assign hit = inc_en && (inc_code == CODE_W'(g));

    always_comb begin
      cnt_d[g] = cnt_q[g];
      if (clr) begin
        cnt_d[g] = '0;
      end else if (hit && !at_max) begin
        cnt_d[g] = cnt_q[g] + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[g] <= '0;
      end else begin
        cnt_q[g] <= cnt_d[g];
      end
    end
  end

endmodule

// File: rtl/hist_seq_div.sv
// Restoring divider, one quotient bit per cycle; a zero divisor yields zero.
module hist_seq_div #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);

  localparam int CW = $clog2(NUM_W + 1);

  logic             run_q, run_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [DEN_W-1:0] rem_q, rem_d;
  logic [NUM_W-1:0] q_q, q_d;
  logic             dz_q, dz_d;
  logic             done_q, done_d;
  logic [DEN_W:0]   rem_sh;
  logic             ge;

  assign rem_sh = {rem_q, q_q[NUM_W-1]};
  assign ge     = rem_sh >= {1'b0, den};

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    q_d    = q_q;
    dz_d   = dz_q;
    done_d = 1'b0;
    if (start) begin
      run_d = 1'b1;
      cnt_d = CW'(NUM_W);
      rem_d = '0;
      q_d   = num;
      dz_d  = (den == '0);
    end else if (run_q) begin
      if (ge) begin
        rem_d = DEN_W'(rem_sh - {1'b0, den});
        q_d   = {q_q[NUM_W-2:0], 1'b1};
      end else begin
        rem_d = rem_sh[DEN_W-1:0];
        q_d   = {q_q[NUM_W-2:0], 1'b0};
      end
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      q_q    <= '0;
      dz_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      q_q    <= q_d;
      dz_q   <= dz_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign quo  = dz_q ? '0 : q_q;

endmodule

// File: rtl/hist_lin_acc.sv
// Running INL sum and the sticky per-pass result flags.
module hist_lin_acc #(
  parameter int FRAC_W = 8,
  parameter int DNL_W  = 33,
  parameter int EXT_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          init,
  input  logic                          clr,
  input  logic                          beat,
  input  logic                          inner,
  input  logic                          cnt_zero,
  input  logic signed [DNL_W-1:0]       dnl,
  output logic signed [DNL_W+EXT_W-1:0] inl,
  output logic                          missing_any,
  output logic                          dnl_exceed
);

  localparam int INL_W = DNL_W + EXT_W;
  localparam logic signed [DNL_W-1:0] POS_ONE = DNL_W'(2 ** FRAC_W);
  localparam logic signed [DNL_W-1:0] NEG_ONE = DNL_W'(-(2 ** FRAC_W));

  logic signed [INL_W-1:0] acc_q, acc_d;
  logic                    miss_q, miss_d;
  logic                    exc_q, exc_d;
  logic                    too_far;

  assign too_far = (dnl > POS_ONE) || (dnl < NEG_ONE);

  always_comb begin
    acc_d  = acc_q;
    miss_d = miss_q;
    exc_d  = exc_q;
    if (init || clr) begin
      acc_d  = '0;
      miss_d = 1'b0;
      exc_d  = 1'b0;
    end else if (beat) begin
      acc_d = acc_q + {{EXT_W{dnl[DNL_W-1]}}, dnl};
      if (cnt_zero) begin
        miss_d = 1'b1;
      end
      if (inner && too_far) begin
        exc_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      miss_q <= 1'b0;
      exc_q  <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      miss_q <= miss_d;
      exc_q  <= exc_d;
    end
  end

  assign inl         = acc_q;
  assign missing_any = miss_q;
  assign dnl_exceed  = exc_q;

endmodule

// File: rtl/adc_hist_linearity.sv
module adc_hist_linearity #(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 8
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           smp_valid,
  input  logic [CODE_W-1:0]                              smp_code,
  input  logic                                           acq_start,
  input  logic                                           acq_stop,
  input  logic                                           cnt_clear,
  output logic                                           busy,
  output logic                                           acq_active,
  output logic                                           res_valid,
  output logic                                           res_last,
  output logic [CODE_W-1:0]                              res_code,
  output logic [CNT_W-1:0]                               res_count,
  output logic                                           res_missing,
  output logic signed [CODE_W+CNT_W+FRAC_W:0]            res_dnl,
  output logic signed [2*CODE_W+CNT_W+FRAC_W:0]          res_inl,
  output logic                                           ovf_flag,
  output logic                                           missing_any,
  output logic                                           dnl_exceed
);

  import adc_hist_pkg::*;

  localparam int NCODE = 1 << CODE_W;
  localparam int INNER = NCODE - 2;
  localparam int TOT_W = CNT_W + CODE_W;
  localparam int NUM_W = TOT_W + FRAC_W;
  localparam int DNL_W = NUM_W + 1;
  localparam logic [CODE_W-1:0] TOP_CODE   = '1;
  localparam logic [CODE_W-1:0] LAST_INNER = CODE_W'(NCODE - 2);
  localparam logic signed [DNL_W-1:0] ONE_LSB = DNL_W'(2 ** FRAC_W);

  hist_st_e            st_q, st_d;
  logic [CODE_W-1:0]   idx_q, idx_d;
  logic [TOT_W-1:0]    tot_q, tot_d;
  logic signed [DNL_W-1:0] dnl_q, dnl_d;
  logic                ovf_q, ovf_d;

  logic                clear_ok, clr, inc_en, sat_hit, init;
  logic                inner, in_pass;
  logic [CNT_W-1:0]    rd_cnt;
  logic [NUM_W-1:0]    div_num, div_quo;
  logic                div_start, div_done;

  assign in_pass  = (st_q == ST_SUM) || (st_q == ST_LOAD) ||
                    (st_q == ST_DIV) || (st_q == ST_EMIT);
  assign clear_ok = !in_pass;
  assign clr      = cnt_clear && clear_ok;
  assign inc_en   = (st_q == ST_ACQ) && smp_valid && !cnt_clear;
  assign init     = (st_q == ST_ACQ) && acq_stop && !cnt_clear;
  assign inner    = (idx_q != '0) && (idx_q != TOP_CODE);

  hist_count_mem #(
    .CODE_W (CODE_W),
    .CNT_W  (CNT_W)
  ) i_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .inc_en   (inc_en),
    .inc_code (smp_code),
    .rd_code  (idx_q),
    .rd_cnt   (rd_cnt),
    .sat_hit  (sat_hit)
  );

  // count * INNER * 2^FRAC_W / total = count / average, in LSB units
  assign div_num   = (NUM_W'(rd_cnt) * NUM_W'(INNER)) << FRAC_W;
  assign div_start = (st_q == ST_LOAD) && inner;

  hist_seq_div #(
    .NUM_W (NUM_W),
    .DEN_W (TOT_W)
  ) i_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (div_num),
    .den   (tot_q),
    .done  (div_done),
    .quo   (div_quo)
  );

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    tot_d = tot_q;
    dnl_d = dnl_q;
    unique case (st_q)
      ST_IDLE: begin
        if (!cnt_clear && acq_start) begin
          st_d = ST_ACQ;
        end
      end
      ST_ACQ: begin
        if (cnt_clear) begin
          st_d = ST_IDLE;
        end else if (acq_stop) begin
          st_d  = ST_SUM;
          idx_d = CODE_W'(1);
          tot_d = '0;
        end
      end
      ST_SUM: begin
        tot_d = tot_q + TOT_W'(rd_cnt);
        if (idx_q == LAST_INNER) begin
          st_d  = ST_LOAD;
          idx_d = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_LOAD: begin
        if (inner) begin
          st_d = ST_DIV;
        end else begin
          dnl_d = '0;
          st_d  = ST_EMIT;
        end
      end
      ST_DIV: begin
        if (div_done) begin
          dnl_d = $signed({1'b0, div_quo}) - ONE_LSB;
          st_d  = ST_EMIT;
        end
      end
      ST_EMIT: begin
        if (idx_q == TOP_CODE) begin
          st_d = ST_DONE;
        end else begin
          idx_d = idx_q + 1'b1;
          st_d  = ST_LOAD;
        end
      end
      ST_DONE: begin
        if (cnt_clear) begin
          st_d = ST_IDLE;
        end else if (acq_start) begin
          st_d = ST_ACQ;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ovf_d = ovf_q;
    if (clr) begin
      ovf_d = 1'b0;
    end else if (sat_hit) begin
      ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      tot_q <= '0;
      dnl_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      tot_q <= tot_d;
      dnl_q <= dnl_d;
      ovf_q <= ovf_d;
    end
  end

  hist_lin_acc #(
    .FRAC_W (FRAC_W),
    .DNL_W  (DNL_W),
    .EXT_W  (CODE_W)
  ) i_acc (
    .clk         (clk),
    .rst_n       (rst_n),
    .init        (init),
    .clr         (clr),
    .beat        (res_valid),
    .inner       (inner),
    .cnt_zero    (res_missing),
    .dnl         (dnl_q),
    .inl         (res_inl),
    .missing_any (missing_any),
    .dnl_exceed  (dnl_exceed)
  );

  assign busy        = in_pass;
  assign acq_active  = (st_q == ST_ACQ);
  assign res_valid   = (st_q == ST_EMIT);
  assign res_last    = res_valid && (idx_q == TOP_CODE);
  assign res_code    = idx_q;
  assign res_count   = rd_cnt;
  assign res_missing = (rd_cnt == '0);
  assign res_dnl     = dnl_q;
  assign ovf_flag    = ovf_q;

endmodule

// File: rtl/adc_hist_chk.sv
module adc_hist_chk #(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 8
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  cnt_clear,
  input logic                                  busy,
  input logic                                  acq_active,
  input logic                                  res_valid,
  input logic                                  res_last,
  input logic [CODE_W-1:0]                     res_code,
  input logic [CNT_W-1:0]                      res_count,
  input logic                                  res_missing,
  input logic signed [CODE_W+CNT_W+FRAC_W:0]   res_dnl,
  input logic signed [2*CODE_W+CNT_W+FRAC_W:0] res_inl,
  input logic                                  ovf_flag
);

  localparam int DNL_W = CODE_W + CNT_W + FRAC_W + 1;
  localparam logic signed [DNL_W-1:0] NEG_ONE = DNL_W'(-(2 ** FRAC_W));

  p_end_dnl_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && ((res_code == '0) || (&res_code)) |-> (res_dnl == '0));

  p_inl_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_code <= CODE_W'(1)) |-> (res_inl == '0));

  p_missing_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_missing == (res_count == '0)));

  p_last_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_last == (&res_code)));

  p_beat_in_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (busy && !acq_active));

  p_single_cycle_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_dnl_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_dnl < NEG_ONE));

  p_ovf_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !cnt_clear |=> ovf_flag);

endmodule

bind adc_hist_linearity adc_hist_chk #(
  .CODE_W (CODE_W),
  .CNT_W  (CNT_W),
  .FRAC_W (FRAC_W)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cnt_clear   (cnt_clear),
  .busy        (busy),
  .acq_active  (acq_active),
  .res_valid   (res_valid),
  .res_last    (res_last),
  .res_code    (res_code),
  .res_count   (res_count),
  .res_missing (res_missing),
  .res_dnl     (res_dnl),
  .res_inl     (res_inl),
  .ovf_flag    (ovf_flag)
);

// File: tb/test_adc_hist_linearity.sv
module test_adc_hist_linearity;

  localparam int CW    = 4;
  localparam int NW    = 8;
  localparam int FW    = 8;
  localparam int NC    = 1 << CW;
  localparam int INN   = NC - 2;
  localparam int ONE   = 1 << FW;
  localparam int CMAX  = (1 << NW) - 1;
  localparam int DW    = CW + NW + FW + 1;
  localparam int IW    = 2 * CW + NW + FW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          smp_valid = 1'b0;
  logic [CW-1:0] smp_code  = '0;
  logic          acq_start = 1'b0;
  logic          acq_stop  = 1'b0;
  logic          cnt_clear = 1'b0;

  logic                 busy, acq_active, res_valid, res_last, res_missing;
  logic [CW-1:0]        res_code;
  logic [NW-1:0]        res_count;
  logic signed [DW-1:0] res_dnl;
  logic signed [IW-1:0] res_inl;
  logic                 ovf_flag, missing_any, dnl_exceed;

  adc_hist_linearity #(.CODE_W(CW), .CNT_W(NW), .FRAC_W(FW)) i_adc_hist_linearity (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
    .acq_start(acq_start), .acq_stop(acq_stop), .cnt_clear(cnt_clear),
    .busy(busy), .acq_active(acq_active), .res_valid(res_valid),
    .res_last(res_last), .res_code(res_code), .res_count(res_count),
    .res_missing(res_missing), .res_dnl(res_dnl), .res_inl(res_inl),
    .ovf_flag(ovf_flag), .missing_any(missing_any), .dnl_exceed(dnl_exceed)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // behavioural reference state
  int m_cnt [NC];
  bit m_acq = 1'b0;
  bit m_ovf = 1'b0;
  bit m_pass = 1'b0;
  int e_dnl [NC];
  int e_inl [NC];
  int e_idx = 0;
  bit e_miss = 1'b0;
  bit e_exc = 1'b0;
  bit e_zero_tot = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && smp_valid && m_acq) begin
      if (m_cnt[smp_code] == CMAX) m_ovf = 1'b1;
      else m_cnt[smp_code] = m_cnt[smp_code] + 1;
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(ovf_flag == m_ovf, "R2", "ovf_flag", ovf_flag, m_ovf);
      if (res_valid) begin
        if (!m_pass || e_idx >= NC) begin
          chk(1'b0, "R4", "unexpected beat code", res_code, e_idx);
        end else begin
          chk(res_code == CW'(e_idx), "R4", "beat order", res_code, e_idx);
          chk(res_last == (e_idx == NC - 1), "R4", "res_last", res_last, e_idx == NC - 1);
          chk(int'(res_count) == m_cnt[e_idx], "R1", "count", res_count, m_cnt[e_idx]);
          chk(res_missing == (m_cnt[e_idx] == 0), "R8", "res_missing", res_missing, m_cnt[e_idx] == 0);
          if (e_idx == 0 || e_idx == NC - 1)
            chk(longint'(res_dnl) == e_dnl[e_idx], "R6", "end DNL", res_dnl, e_dnl[e_idx]);
          else if (e_zero_tot)
            chk(longint'(res_dnl) == e_dnl[e_idx], "R10", "DNL empty", res_dnl, e_dnl[e_idx]);
          else
            chk(longint'(res_dnl) == e_dnl[e_idx], "R5", "DNL", res_dnl, e_dnl[e_idx]);
          chk(longint'(res_inl) == e_inl[e_idx], "R7", "INL", res_inl, e_inl[e_idx]);
          e_idx++;
        end
      end
    end
  end

  task automatic sample(input int code);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_code  = CW'(code);
    @(posedge clk);
    #1 smp_valid = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk);
    acq_start = 1'b1;
    @(posedge clk);
    #1 acq_start = 1'b0;
    m_acq = 1'b1;
  endtask

  task automatic do_clear();
    @(negedge clk);
    cnt_clear = 1'b1;
    @(posedge clk);
    #1 cnt_clear = 1'b0;
    foreach (m_cnt[i]) m_cnt[i] = 0;
    m_ovf = 1'b0;
    m_acq = 1'b0;
  endtask

  task automatic build_expect();
    int tot = 0;
    int acc = 0;
    for (int k = 1; k < NC - 1; k++) tot += m_cnt[k];
    e_zero_tot = (tot == 0);
    e_miss = 1'b0;
    e_exc  = 1'b0;
    for (int k = 0; k < NC; k++) begin
      if (m_cnt[k] == 0) e_miss = 1'b1;
      if (k == 0 || k == NC - 1) e_dnl[k] = 0;
      else if (tot == 0) e_dnl[k] = -ONE;
      else e_dnl[k] = (m_cnt[k] * INN * ONE) / tot - ONE;
      if (k != 0 && k != NC - 1 && (e_dnl[k] > ONE || e_dnl[k] < -ONE)) e_exc = 1'b1;
      e_inl[k] = acc;
      acc += e_dnl[k];
    end
  endtask

  task automatic run_pass(input bit noise, input bit mid_clear);
    build_expect();
    e_idx  = 0;
    m_pass = 1'b1;
    @(negedge clk);
    acq_stop = 1'b1;
    @(posedge clk);
    #1 acq_stop = 1'b0;
    m_acq = 1'b0;
    fork
      begin
        if (noise) begin
          for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_code  = CW'((i * 5) % NC);
          end
          @(negedge clk);
          smp_valid = 1'b0;
        end
      end
      begin
        if (mid_clear) begin
          repeat (60) @(negedge clk);
          cnt_clear = 1'b1;   // must be ignored while busy (R3)
          @(negedge clk);
          cnt_clear = 1'b0;
        end
      end
      begin
        while (e_idx < NC) @(negedge clk);
      end
    join
    @(negedge clk);
    m_pass = 1'b0;
    chk(busy == 1'b0, "R4", "busy after pass", busy, 0);
    chk(missing_any == e_miss, "R8", "missing_any", missing_any, e_miss);
    chk(dnl_exceed == e_exc, "R9", "dnl_exceed", dnl_exceed, e_exc);
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    foreach (m_cnt[i]) m_cnt[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R4", "reset busy", busy, 0);
    chk(acq_active == 1'b0, "R1", "reset window", acq_active, 0);
    chk(res_valid == 1'b0, "R4", "reset res_valid", res_valid, 0);
    chk(ovf_flag == 1'b0, "R2", "reset ovf", ovf_flag, 0);

    // R1: samples before the window are not counted
    for (int i = 0; i < 5; i++) sample(3);
    // uniform ramp, heavy end bins: excluded from the average (R5, R6)
    do_start();
    for (int k = 0; k < NC; k++) begin
      for (int r = 0; r < ((k == 0 || k == NC - 1) ? 30 : 10); r++) sample(k);
    end
    run_pass(1'b1, 1'b0);

    // uneven steps, one missing code, a wide step, clear during the pass (R3, R9)
    do_clear();
    do_start();
    for (int k = 0; k < NC; k++) begin
      int n;
      n = (k == 5) ? 0 : (k == 7) ? 20 : (k % 3) + 1;
      for (int r = 0; r < n; r++) sample(k);
    end
    run_pass(1'b0, 1'b1);

    // exact two-LSB step is +1 LSB and does not trip the exceed flag (R9)
    do_clear();
    do_start();
    for (int k = 0; k < NC; k++) begin
      int n;
      n = (k == 2) ? 2 : (k == 3) ? 0 : 1;
      for (int r = 0; r < n; r++) sample(k);
    end
    run_pass(1'b0, 1'b0);

    // empty histogram (R10)
    do_clear();
    do_start();
    run_pass(1'b0, 1'b0);

    // saturation (R2), then clear drops the flag (R3)
    do_clear();
    do_start();
    for (int i = 0; i < CMAX + 45; i++) sample(3);
    for (int i = 0; i < 10; i++) sample(8);
    @(negedge clk);
    chk(ovf_flag == 1'b1, "R2", "ovf after saturation", ovf_flag, 1);
    run_pass(1'b0, 1'b0);
    do_clear();
    @(negedge clk);
    chk(ovf_flag == 1'b0, "R3", "ovf after clear", ovf_flag, 0);
    chk(acq_active == 1'b0, "R3", "window after clear", acq_active, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule